// File: doc/BRIEF.md
# Posted Write Target Acceptor

This block is the target side of one direction of a bridge's posted write path. It watches a simplified parallel bus and claims only memory write and memory write-and-invalidate bursts. It claims a burst only when the internal 64-entry posted write queue has enough free room. When it claims, it answers with medium decode timing and then takes data phases into the queue. It ends a burst with a disconnect when the burst reaches an internal address boundary or when the queue fills.

For each claimed burst, the queue first receives a header entry that carries the start address and the stored command. One data entry then follows for every data phase accepted. At claim time the block decides whether a write-and-invalidate is stored as it is or downgraded to a plain memory write. A global conversion input can force the downgrade, and so can a lack of room for a full cache line. The queue's read side is a show-ahead port, and the replay logic on the far side drains it.

Bus signals are active high. Every bus output comes straight from a state register.

Top module: `pwt_acceptor`

## Requirements
- R1: While and after rst_ni is low, devsel_o, trdy_o, stop_o and q_valid_o are 0.
- R2: The address cycle is the first cycle in which frame_i is high after a cycle with frame_i low, with the block idle. For a claimed burst, devsel_o and trdy_o both rise two cycles after the address cycle. trdy_o is never high without devsel_o.
- R3: Only cmd_i 4'b0111 (memory write) and 4'b1111 (write-and-invalidate) are claimed. Other commands, such as 4'b0011 (I/O write) and 4'b1011 (configuration write), raise no devsel_o and add no queue entry.
- R4: A burst is claimed only if the queue has at least 8 free entries in the address cycle. Otherwise no devsel_o is raised and no entry is added.
- R5: A claim pushes one header entry {sot=1, cmd=stored command, be=4'h0, data=ad_i of the address cycle}. After that, each cycle with trdy_o and irdy_i high pushes {sot=0, cmd=stored command, be=be_i, data=ad_i}. A cycle with irdy_i low pushes nothing.
- R6: If a data phase is accepted with frame_i low, devsel_o and trdy_o drop in the next cycle and stop_o stays low.
- R7: With conv_all_i at 1, a write-and-invalidate is stored with command 4'b0111.
- R8: With conv_all_i at 0, a write-and-invalidate is stored as 4'b1111 only when line_size_i is valid and free entries are at least line_size_i in the address cycle. Otherwise it is stored as 4'b0111.
- R9: Consider a data phase accepted with frame_i high whose next dword address hits a boundary. For stored 4'b1111 the boundary is a multiple of line_size_i. For stored 4'b0111 it is the point where dword address bits [9:0] are 0 (a 4 KB boundary). In the next cycle trdy_o goes low while stop_o and devsel_o are high. They stay that way until frame_i is seen low, and all three are low in the cycle after.
- R10: A data phase that leaves the queue with 64 entries, with frame_i high, causes the same disconnect as R9. The queue never holds more than 64 entries.
- R11: A line_size_i that is not 1, 2, 4, 8 or 16 is invalid, and a write-and-invalidate is then stored as 4'b0111.
- R12: q_valid_o is high whenever the queue holds an entry, and q_* show the oldest entry. pop_i removes that entry at the clock edge. pop_i on an empty queue has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Initiator burst in progress |
| irdy_i | input | 1 | Initiator data ready |
| cmd_i | input | 4 | Bus command, sampled in the address cycle |
| ad_i | input | 32 | Address in the address cycle, data in data phases |
| be_i | input | 4 | Byte enables of the data phase |
| conv_all_i | input | 1 | Store every write-and-invalidate as a memory write |
| line_size_i | input | 5 | Cache-line size in dwords |
| devsel_o | output | 1 | Burst claimed |
| trdy_o | output | 1 | Target ready for data |
| stop_o | output | 1 | Target disconnect |
| pop_i | input | 1 | Remove the head queue entry |
| q_valid_o | output | 1 | Queue not empty |
| q_sot_o | output | 1 | Head entry is a burst header |
| q_cmd_o | output | 4 | Head entry stored command |
| q_be_o | output | 4 | Head entry byte enables |
| q_data_o | output | 32 | Head entry address or data |

## Verification
A wrong claim decision shows at the ports two cycles after the address cycle. devsel_o either appears or stays low against expectation, and a header entry appears at the queue head or fails to appear. A stale burst address or boundary mask shows in the cycle after the transfer that should have hit the boundary, as trdy_o held high or a stop_o raised too early. A wrong conversion or a miscounted fill level shows in the stored command read back at the queue head, or in a missing disconnect on the 64th entry.

// File: rtl/pwt_pkg.sv
package pwt_pkg;
  localparam logic [3:0] CMD_MW  = 4'b0111;
  localparam logic [3:0] CMD_MWI = 4'b1111;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DATA = 2'd2,
    ST_DISC = 2'd3
  } state_e;

  typedef struct packed {
    logic        sot;
    logic [3:0]  cmd;
    logic [3:0]  be;
    logic [31:0] data;
  } entry_t;
endpackage

// File: rtl/pwt_fifo.sv
module pwt_fifo #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  pwt_pkg::entry_t  wdata_i,
  input  logic             pop_i,
  output logic             valid_o,
  output pwt_pkg::entry_t  rdata_o,
  output logic [CW-1:0]    count_o,
  output logic [CW-1:0]    count_next_o,
  output logic [CW-1:0]    free_o
);
  pwt_pkg::entry_t mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          pop_eff;

  assign pop_eff      = pop_i && (cnt_q != '0);
  assign count_o      = cnt_q;
  assign free_o       = CW'(DEPTH) - cnt_q;
  assign valid_o      = (cnt_q != '0);
  assign rdata_o      = mem[rd_ptr_q];
  assign count_next_o = cnt_q + CW'(push_i) - CW'(pop_eff);

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i)  wr_ptr_q <= bump(wr_ptr_q);
      if (pop_eff) rd_ptr_q <= bump(rd_ptr_q);
      cnt_q <= count_next_o;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_ptr_q] <= wdata_i;
  end
endmodule

// File: rtl/pwt_policy.sv
module pwt_policy #(
  parameter int DEPTH    = 64,
  parameter int MIN_FREE = 8,
  parameter int MAX_LINE = 16,
  parameter int BOUND_DW = 1024,
  localparam int CW  = $clog2(DEPTH + 1),
  localparam int LSW = $clog2(MAX_LINE + 1),
  localparam int BW  = $clog2(BOUND_DW)
) (
  input  logic [3:0]     cmd_i,
  input  logic           conv_all_i,
  input  logic [LSW-1:0] line_size_i,
  input  logic [CW-1:0]  free_i,
  output logic           claim_o,
  output logic [3:0]     store_cmd_o,
  output logic [BW-1:0]  mask_o
);
  import pwt_pkg::*;
  logic posted, ls_ok, keep_mwi;

  assign posted  = (cmd_i == CMD_MW) || (cmd_i == CMD_MWI);
  assign claim_o = posted && (free_i >= CW'(MIN_FREE));

  // power of two, non-zero, within the supported maximum
  assign ls_ok = (line_size_i != '0) &&
                 ((line_size_i & (line_size_i - LSW'(1))) == '0) &&
                 (line_size_i <= LSW'(MAX_LINE));

  assign keep_mwi = (cmd_i == CMD_MWI) && !conv_all_i && ls_ok &&
                    (free_i >= CW'(line_size_i));

  assign store_cmd_o = keep_mwi ? CMD_MWI : CMD_MW;
  assign mask_o      = keep_mwi ? (BW'(line_size_i) - BW'(1)) : {BW{1'b1}};
endmodule

// File: rtl/pwt_ctrl.sv
module pwt_ctrl #(
  parameter int DEPTH    = 64,
  parameter int BOUND_DW = 1024,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int BW = $clog2(BOUND_DW)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            frame_i,
  input  logic            irdy_i,
  input  logic [31:0]     ad_i,
  input  logic [3:0]      be_i,
  input  logic            claim_i,
  input  logic [3:0]      store_cmd_i,
  input  logic [BW-1:0]   mask_i,
  input  logic [CW-1:0]   count_next_i,
  output logic            push_o,
  output pwt_pkg::entry_t push_data_o,
  output logic            devsel_o,
  output logic            trdy_o,
  output logic            stop_o
);
  import pwt_pkg::*;
  state_e        st_q, st_d;
  logic          frame_q;
  logic [3:0]    cmd_q, cmd_d;
  logic [BW-1:0] mask_q, mask_d;
  logic [BW-1:0] addr_q, addr_d;
  logic          start, hit, full_next;

  assign start     = frame_i && !frame_q;
  assign hit       = ((addr_q + BW'(1)) & mask_q) == '0;
  assign full_next = (count_next_i == CW'(DEPTH));

  always_comb begin
    st_d        = st_q;
    cmd_d       = cmd_q;
    mask_d      = mask_q;
    addr_d      = addr_q;
    push_o      = 1'b0;
    push_data_o = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (start && claim_i) begin
          push_o           = 1'b1;
          push_data_o.sot  = 1'b1;
          push_data_o.cmd  = store_cmd_i;
          push_data_o.be   = 4'h0;
          push_data_o.data = ad_i;
          cmd_d            = store_cmd_i;
          mask_d           = mask_i;
          addr_d           = ad_i[BW+1:2];
          st_d             = ST_WAIT;
        end
      end
      ST_WAIT: st_d = ST_DATA;
      ST_DATA: begin
        if (irdy_i) begin
          push_o           = 1'b1;
          push_data_o.sot  = 1'b0;
          push_data_o.cmd  = cmd_q;
          push_data_o.be   = be_i;
          push_data_o.data = ad_i;
          addr_d           = addr_q + BW'(1);
          if (!frame_i)              st_d = ST_IDLE;
          else if (hit || full_next) st_d = ST_DISC;
        end else if (!frame_i) begin
          st_d = ST_IDLE;
        end
      end
      ST_DISC: if (!frame_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      frame_q <= 1'b0;
      cmd_q   <= '0;
      mask_q  <= '0;
      addr_q  <= '0;
    end else begin
      st_q    <= st_d;
      frame_q <= frame_i;
      cmd_q   <= cmd_d;
      mask_q  <= mask_d;
      addr_q  <= addr_d;
    end
  end

  assign devsel_o = (st_q == ST_DATA) || (st_q == ST_DISC);
  assign trdy_o   = (st_q == ST_DATA);
  assign stop_o   = (st_q == ST_DISC);
endmodule

// File: rtl/pwt_acceptor.sv
module pwt_acceptor #(
  parameter int DEPTH    = 64,
  parameter int MIN_FREE = 8,
  parameter int MAX_LINE = 16,
  parameter int BOUND_DW = 1024,
  localparam int CW  = $clog2(DEPTH + 1),
  localparam int LSW = $clog2(MAX_LINE + 1),
  localparam int BW  = $clog2(BOUND_DW)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           frame_i,
  input  logic           irdy_i,
  input  logic [3:0]     cmd_i,
  input  logic [31:0]    ad_i,
  input  logic [3:0]     be_i,
  input  logic           conv_all_i,
  input  logic [LSW-1:0] line_size_i,
  output logic           devsel_o,
  output logic           trdy_o,
  output logic           stop_o,
  input  logic           pop_i,
  output logic           q_valid_o,
  output logic           q_sot_o,
  output logic [3:0]     q_cmd_o,
  output logic [3:0]     q_be_o,
  output logic [31:0]    q_data_o
);
  pwt_pkg::entry_t push_data, head;
  logic            push, claim;
  logic [3:0]      store_cmd;
  logic [BW-1:0]   mask;
  logic [CW-1:0]   fifo_cnt, fifo_cnt_next, fifo_free;

  pwt_policy #(
    .DEPTH(DEPTH), .MIN_FREE(MIN_FREE), .MAX_LINE(MAX_LINE), .BOUND_DW(BOUND_DW)
  ) u_policy (
    .cmd_i(cmd_i), .conv_all_i(conv_all_i), .line_size_i(line_size_i),
    .free_i(fifo_free), .claim_o(claim), .store_cmd_o(store_cmd), .mask_o(mask)
  );

  pwt_ctrl #(.DEPTH(DEPTH), .BOUND_DW(BOUND_DW)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_i(frame_i), .irdy_i(irdy_i),
    .ad_i(ad_i), .be_i(be_i), .claim_i(claim), .store_cmd_i(store_cmd),
    .mask_i(mask), .count_next_i(fifo_cnt_next), .push_o(push),
    .push_data_o(push_data), .devsel_o(devsel_o), .trdy_o(trdy_o), .stop_o(stop_o)
  );

  pwt_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push), .wdata_i(push_data),
    .pop_i(pop_i), .valid_o(q_valid_o), .rdata_o(head), .count_o(fifo_cnt),
    .count_next_o(fifo_cnt_next), .free_o(fifo_free)
  );

  assign q_sot_o  = head.sot;
  assign q_cmd_o  = head.cmd;
  assign q_be_o   = head.be;
  assign q_data_o = head.data;
endmodule

// File: rtl/pwt_acceptor_chk.sv
module pwt_acceptor_chk #(
  parameter int DEPTH    = 64,
  parameter int MIN_FREE = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          frame_i,
  input logic [3:0]    cmd_i,
  input logic          devsel_o,
  input logic          trdy_o,
  input logic          stop_o,
  input logic          push,
  input logic          push_sot,
  input logic [CW-1:0] count,
  input logic [CW-1:0] free
);
  logic posted;
  assign posted = (cmd_i == 4'b0111) || (cmd_i == 4'b1111);

  AST_TRDY_HAS_DEVSEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trdy_o |-> devsel_o); // R2
  AST_MEDIUM_DECODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(devsel_o) |-> ($past(frame_i, 2) && !$past(frame_i, 3) && trdy_o)); // R2
  AST_NONPOSTED_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!devsel_o && frame_i && !$past(frame_i) && !posted) |-> ##2 !$rose(devsel_o)); // R3
  AST_CLAIM_MARGIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(devsel_o) |-> ($past(free, 2) >= CW'(MIN_FREE))); // R4
  AST_HEADER_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && push_sot) |-> !devsel_o); // R5
  AST_STOP_NOT_TRDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stop_o && trdy_o)); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push |-> (count < CW'(DEPTH))); // R10
endmodule

bind pwt_acceptor pwt_acceptor_chk #(.DEPTH(DEPTH), .MIN_FREE(MIN_FREE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .frame_i(frame_i), .cmd_i(cmd_i),
  .devsel_o(devsel_o), .trdy_o(trdy_o), .stop_o(stop_o), .push(push),
  .push_sot(push_data.sot), .count(fifo_cnt), .free(fifo_free)
);

// File: tb/pwt_acceptor_test.sv
`timescale 1ns/1ps
module pwt_acceptor_test;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic frame = 1'b0, irdy = 1'b0, conv = 1'b0, pop = 1'b0;
  logic [3:0] cmd = 4'h0, be = 4'h0;
  logic [31:0] ad = '0;
  logic [4:0] ls = 5'd8;
  logic devsel_o, trdy_o, stop_o, q_valid_o, q_sot_o;
  logic [3:0] q_cmd_o, q_be_o;
  logic [31:0] q_data_o;

  int checks = 0, fails = 0;
  string cur_req = "R1";

  always #10 clk_i = ~clk_i;

  pwt_acceptor uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_i(frame), .irdy_i(irdy), .cmd_i(cmd),
    .ad_i(ad), .be_i(be), .conv_all_i(conv), .line_size_i(ls),
    .devsel_o(devsel_o), .trdy_o(trdy_o), .stop_o(stop_o), .pop_i(pop),
    .q_valid_o(q_valid_o), .q_sot_o(q_sot_o), .q_cmd_o(q_cmd_o),
    .q_be_o(q_be_o), .q_data_o(q_data_o)
  );

  // reference model
  logic [40:0] mq[$];
  int          m_st = 0;
  logic        m_fd = 1'b0;
  logic [3:0]  m_cmd = 4'h0;
  logic [9:0]  m_mask = '0, m_addr = '0;

  always @(posedge clk_i) begin
    int sz, fr, nst;
    bit dpop, dpush, keep, vls;
    logic [40:0] e;
    if (!rst_ni) begin
      m_st = 0; m_fd = 1'b0; mq.delete();
    end else begin
      sz = mq.size(); fr = 64 - sz; nst = m_st;
      dpop = pop && sz > 0; dpush = 1'b0; e = '0;
      case (m_st)
        0: if (frame && !m_fd && (cmd == 4'h7 || cmd == 4'hF) && fr >= 8) begin
             vls  = ls inside {5'd1, 5'd2, 5'd4, 5'd8, 5'd16};
             keep = (cmd == 4'hF) && !conv && vls && fr >= int'(ls);
             m_cmd  = keep ? 4'hF : 4'h7;
             m_mask = keep ? 10'(ls - 5'd1) : 10'h3FF;
             m_addr = ad[11:2];
             e = {1'b1, m_cmd, 4'h0, ad}; dpush = 1'b1; nst = 1;
           end
        1: nst = 2;
        2: if (irdy) begin
             e = {1'b0, m_cmd, be, ad}; dpush = 1'b1;
             m_addr = m_addr + 10'd1;
             if (!frame) nst = 0;
             else if (((m_addr & m_mask) == 10'd0) || (sz - int'(dpop) + 1 == 64)) nst = 3;
           end else if (!frame) nst = 0;
        default: if (!frame) nst = 0;
      endcase
      if (dpop) void'(mq.pop_front());
      if (dpush) mq.push_back(e);
      m_fd = frame; m_st = nst;
    end
  end

  task automatic chk(input string what, input logic [40:0] act, input logic [40:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni) begin
      chk("devsel", 41'(devsel_o), 41'(m_st >= 2));
      chk("trdy",   41'(trdy_o),   41'(m_st == 2));
      chk("stop",   41'(stop_o),   41'(m_st == 3));
      chk("q_valid", 41'(q_valid_o), 41'(mq.size() > 0));
      if (mq.size() > 0)
        chk("head", {q_sot_o, q_cmd_o, q_be_o, q_data_o}, mq[0]);
    end
  end

  task automatic burst(input logic [3:0] c, input logic [31:0] a, input int n, input bit ws);
    int i = 0, waitc = 0;
    bit t, s, d, stalled = 1'b0;
    @(posedge clk_i); #1;
    frame = 1'b1; irdy = 1'b0; cmd = c; ad = a; be = 4'h0;
    @(posedge clk_i); #1;
    irdy = 1'b1; ad = {a[15:0], 16'(i)}; be = 4'(i) ^ 4'hA; frame = (n > 1);
    forever begin
      @(negedge clk_i); t = trdy_o; s = stop_o; d = devsel_o;
      @(posedge clk_i); #1;
      if (t && irdy) i++;
      if (i >= n) begin frame = 1'b0; irdy = 1'b0; break; end
      if (s) begin
        frame = 1'b0; irdy = 1'b1;
        @(posedge clk_i); #1; irdy = 1'b0; break;
      end
      if (!d) waitc++;
      if (!d && waitc > 4) begin frame = 1'b0; irdy = 1'b0; break; end
      ad = {a[15:0], 16'(i)}; be = 4'(i) ^ 4'hA; frame = (i < n - 1);
      if (ws && i == 1 && !stalled) begin irdy = 1'b0; frame = 1'b1; stalled = 1'b1; end
      else irdy = 1'b1;
    end
    @(posedge clk_i); #1;
  endtask

  task automatic pops(input int k);
    @(posedge clk_i); #1; pop = 1'b1;
    repeat (k) @(posedge clk_i);
    #1; pop = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #5;
    cur_req = "R1";
    chk("reset outs", 41'({devsel_o, trdy_o, stop_o, q_valid_o}), 41'(0));
    @(posedge clk_i); #1; rst_ni = 1'b1;
    repeat (2) @(posedge clk_i);

    cur_req = "R2"; burst(4'h7, 32'h1000_0100, 4, 1'b1);   // also R5, R6
    cur_req = "R6"; burst(4'h7, 32'h1000_0200, 1, 1'b0);
    cur_req = "R3"; burst(4'h3, 32'h1000_0300, 3, 1'b0);
    burst(4'hB, 32'h1000_0400, 3, 1'b0);
    burst(4'h6, 32'h1000_0500, 3, 1'b0);
    cur_req = "R8"; ls = 5'd8; burst(4'hF, 32'h1000_0014, 6, 1'b0); // line disconnect R9
    cur_req = "R9"; ls = 5'd4; burst(4'hF, 32'h1000_0020, 6, 1'b1);
    burst(4'h7, 32'h1000_0FF8, 5, 1'b0);
    cur_req = "R7"; conv = 1'b1; burst(4'hF, 32'h1000_0014, 6, 1'b0);
    conv = 1'b0;
    cur_req = "R11"; ls = 5'd6; burst(4'hF, 32'h1000_0014, 6, 1'b0);
    ls = 5'd0; burst(4'hF, 32'h1000_0034, 3, 1'b0);
    cur_req = "R12"; pops(80);

    cur_req = "R10"; ls = 5'd16;
    burst(4'h7, 32'h2000_0000, 40, 1'b0);
    burst(4'h7, 32'h2000_1000, 30, 1'b0);
    cur_req = "R4"; burst(4'h7, 32'h2000_2000, 3, 1'b0);
    pops(7);
    burst(4'hF, 32'h2000_3000, 3, 1'b0);
    pops(1);
    cur_req = "R8"; burst(4'hF, 32'h2000_3000, 3, 1'b0);
    cur_req = "R12"; pops(70);
    repeat (3) @(posedge clk_i);
    #5;
    chk("drained", 41'(q_valid_o), 41'(0));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    fails++; checks++;
    $display("FAIL %s watchdog act=hung exp=done", cur_req);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule